// File: doc/BRIEF.md
# Banked Lane Scratchpad

This block is a 64 KB on-chip scratchpad that many SIMD lanes share. A group of lanes issues one operation at a time. It is a read or a write, and each lane brings its own byte address and its own write data. The storage is split into 32 independent banks of 32-bit words. A lane's bank comes from the word-interleaved low bits of its address, so neighbouring words sit in neighbouring banks.

Each bank serves one lane per clock. When several active lanes map to the same bank, the bank takes them one at a time, lowest lane index first, so the operation lasts as many cycles as the busiest bank has requests. When every active lane has been served, a one-cycle done pulse marks the end. A broadcast read mode skips the per-lane queuing: it fetches one word, at the address of the lowest active lane, and hands it to every active lane in a single service cycle.

The block is meant to sit beside a lane array. Software that lays its data out across banks finishes in few cycles. Data that piles onto one bank costs one cycle for each lane on that bank.

Top module: `scratch_top`

## Requirements
- R1: After reset, busy and done are low and every lane's read data is zero.
- R2: A byte address maps to bank = address[6:2] and to word row = address[15:7]. Address bits [1:0] have no effect, and each word is 32 bits.
- R3: Every bank serves at most one lane per cycle. If start is sampled at clock edge t, done is high for exactly one cycle after edge t+K. K is the largest number of active lanes that map to any one bank, and K is at least 1.
- R4: Lanes that access consecutive words (lane i at base+4*i) never conflict: 32 such lanes finish with K=1 and 64 lanes finish with K=2.
- R5: If all N active lanes target one bank, the operation takes K=N cycles, for writes and for reads alike.
- R6: A lane whose valid bit is clear is not served, adds no cycles and keeps its read data. With an all-zero mask, K=1.
- R7: Within a bank, lanes are served in ascending lane order. When several lanes write the same address in one operation, the value from the highest-index lane remains.
- R8: With broadcast set, the operation takes K=1. Every active lane receives the word at the address of the lowest-index active lane, and inactive lanes keep their read data. Broadcast never writes, even when write enable is set.
- R9: busy is high from the edge that samples start until the edge that raises done. A start pulse while busy is ignored, along with the inputs that come with it.
- R10: Read data is registered. It is valid when done is high and holds its value until a later read serves that lane. Write operations leave read data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation and captures the request inputs; ignored while busy |
| bcast | input | 1 | Broadcast read mode for this operation |
| we | input | 1 | 1 = write, 0 = read |
| laneValid | input | LANES | Per-lane active mask |
| laneAddr | input | LANES*16 | Per-lane byte address; lane l uses bits [16*l +: 16] |
| laneWdata | input | LANES*32 | Per-lane write data; lane l uses bits [32*l +: 32] |
| laneRdata | output | LANES*32 | Per-lane registered read data; lane l uses bits [32*l +: 32] |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when every active lane has been served |

## Verification
The assertions check the handshake on every cycle. done is a single-cycle pulse that only follows a busy cycle and never overlaps busy. busy only rises in response to start. Read data never moves unless a service cycle came just before. Data placement is different: cycle counts for each bank-conflict pattern, the priority among lanes on one bank, masking, byte-offset aliasing and the broadcast word can only be shown by the bench's scenarios, which compare latency and returned words against values worked out from the address patterns.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
  typedef struct packed {
    logic load;  // capture a new request group
    logic step;  // service one cycle of grants
  } ctrlStrobe_t;
endpackage

// File: rtl/scratch_bank.sv
module scratch_bank #(
  parameter int WORD_W = 32,
  parameter int ROW_W  = 9
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdWord
);
  localparam int ROWS = 1 << ROW_W;

  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wrEn) mem[row] <= wrData;
  end

  assign rdWord = mem[row];
endmodule

// File: rtl/scratch_ctrl.sv
module scratch_ctrl
  import scratch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        allClear,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  logic running;

  always_comb begin
    strobe.load = start && !running;
    strobe.step = running;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= running && allClear;
      if (strobe.load) running <= 1'b1;
      else if (running && allClear) running <= 1'b0;
    end
  end

  assign busy = running;
endmodule

// File: rtl/scratch_datapath.sv
module scratch_datapath
  import scratch_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int BANKS  = 32,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic                     bcast,
  input  logic                     we,
  input  logic [LANES-1:0]         laneValid,
  input  logic [LANES*ADDR_W-1:0]  laneAddr,
  input  logic [LANES*WORD_W-1:0]  laneWdata,
  output logic [LANES*WORD_W-1:0]  laneRdata,
  output logic                     allClear
);
  localparam int OFF_BITS  = $clog2(WORD_W / 8);
  localparam int BANK_BITS = $clog2(BANKS);
  localparam int ROW_W     = ADDR_W - BANK_BITS - OFF_BITS;
  localparam int LANE_W    = $clog2(LANES);

  logic [LANES-1:0]  pendQ;
  logic              weQ, bcastQ;
  logic [ADDR_W-1:0] addrQ  [LANES];
  logic [WORD_W-1:0] wdataQ [LANES];
  logic [WORD_W-1:0] rdataQ [LANES];

  logic [BANK_BITS-1:0] laneBank [LANES];
  logic [ROW_W-1:0]     laneRow  [LANES];
  logic [BANKS-1:0]     winValid;
  logic [LANE_W-1:0]    winIdx   [BANKS];
  logic [WORD_W-1:0]    bankWord [BANKS];
  logic [LANES-1:0]     grant;
  logic [LANE_W-1:0]    leadIdx;
  logic                 leadFound;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      laneBank[l] = addrQ[l][OFF_BITS +: BANK_BITS];
      laneRow[l]  = addrQ[l][OFF_BITS + BANK_BITS +: ROW_W];
    end
  end

  // Fixed-priority pick per bank: lowest pending lane index wins.
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      winValid[b] = 1'b0;
      winIdx[b]   = '0;
      for (int l = 0; l < LANES; l++) begin
        if (!winValid[b] && pendQ[l] && laneBank[l] == BANK_BITS'(b)) begin
          winValid[b] = 1'b1;
          winIdx[b]   = LANE_W'(l);
        end
      end
    end
  end

  // Lowest pending lane overall supplies the broadcast address.
  always_comb begin
    leadFound = 1'b0;
    leadIdx   = '0;
    for (int l = 0; l < LANES; l++) begin
      if (!leadFound && pendQ[l]) begin
        leadFound = 1'b1;
        leadIdx   = LANE_W'(l);
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      grant[l] = bcastQ ? pendQ[l]
                        : (pendQ[l] && winValid[laneBank[l]] &&
                           winIdx[laneBank[l]] == LANE_W'(l));
    end
  end

  assign allClear = ((pendQ & ~grant) == '0);

  for (genvar b = 0; b < BANKS; b++) begin : gBank
    scratch_bank #(.WORD_W(WORD_W), .ROW_W(ROW_W)) uBank (
      .clk    (clk),
      .wrEn   (strobe.step && weQ && !bcastQ && winValid[b]),
      .row    (laneRow[winIdx[b]]),
      .wrData (wdataQ[winIdx[b]]),
      .rdWord (bankWord[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      weQ    <= 1'b0;
      bcastQ <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        addrQ[l]  <= '0;
        wdataQ[l] <= '0;
        rdataQ[l] <= '0;
      end
    end else if (strobe.load) begin
      pendQ  <= laneValid;
      weQ    <= we;
      bcastQ <= bcast;
      for (int l = 0; l < LANES; l++) begin
        addrQ[l]  <= laneAddr[l*ADDR_W +: ADDR_W];
        wdataQ[l] <= laneWdata[l*WORD_W +: WORD_W];
      end
    end else if (strobe.step) begin
      pendQ <= pendQ & ~grant;
      for (int l = 0; l < LANES; l++) begin
        if (grant[l] && (bcastQ || !weQ)) begin
          rdataQ[l] <= bcastQ ? bankWord[laneBank[leadIdx]]
                              : bankWord[laneBank[l]];
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) laneRdata[l*WORD_W +: WORD_W] = rdataQ[l];
  end
endmodule

// File: rtl/scratch_top.sv
module scratch_top
  import scratch_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int BANKS  = 32,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    bcast,
  input  logic                    we,
  input  logic [LANES-1:0]        laneValid,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  input  logic [LANES*WORD_W-1:0] laneWdata,
  output logic [LANES*WORD_W-1:0] laneRdata,
  output logic                    busy,
  output logic                    done
);
  ctrlStrobe_t strobe;
  logic        allClear;

  scratch_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .allClear (allClear),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  scratch_datapath #(
    .LANES(LANES), .BANKS(BANKS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bcast     (bcast),
    .we        (we),
    .laneValid (laneValid),
    .laneAddr  (laneAddr),
    .laneWdata (laneWdata),
    .laneRdata (laneRdata),
    .allClear  (allClear)
  );
endmodule

// File: rtl/scratch_checker.sv
module scratch_checker #(
  parameter int RD_W = 2048
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [RD_W-1:0] laneRdata
);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> !busy);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busy) |-> $stable(laneRdata));
endmodule

bind scratch_top scratch_checker #(.RD_W(LANES*WORD_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .laneRdata (laneRdata)
);

// File: tb/sim_scratch_top.sv
`timescale 1ns/1ps
module sim_scratch_top;
  localparam int N = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic            bcast = 1'b0;
  logic            we = 1'b0;
  logic [N-1:0]    valid = '0;
  logic [N*16-1:0] addrBus = '0;
  logic [N*32-1:0] wdBus = '0;
  logic [N*32-1:0] rdBus;
  logic            busy, done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  scratch_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .bcast(bcast), .we(we),
    .laneValid(valid), .laneAddr(addrBus), .laneWdata(wdBus),
    .laneRdata(rdBus), .busy(busy), .done(done)
  );

  function automatic logic [31:0] rd(input int l);
    return rdBus[l*32 +: 32];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setLane(input int l, input logic [15:0] a, input logic [31:0] d);
    addrBus[l*16 +: 16] = a;
    wdBus[l*32 +: 32]   = d;
  endtask

  // Start an operation and return its latency K (done seen after edge t+K).
  // With poke set, a second start arrives mid-operation with junk data.
  task automatic runOp(input logic [N-1:0] m, input logic b, input logic w,
                       input bit poke, output int lat, output bit busyOk);
    @(negedge clk);
    valid = m; bcast = b; we = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    busyOk = 1'b1;
    while (!done && lat < 300) begin
      if (!busy) busyOk = 1'b0;
      if (poke && lat == 3) begin
        start = 1'b1; we = 1'b1;
        for (int l = 0; l < N; l++) wdBus[l*32 +: 32] = 32'hDEAD_0000 + l;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (busy) busyOk = 1'b0;
  endtask

  task automatic tReset();
    bit allZero = 1'b1;
    for (int l = 0; l < N; l++) if (rd(l) != 0) allZero = 1'b0;
    chk(!busy, "R1 busy after reset", {31'b0, busy}, 0);
    chk(!done, "R1 done after reset", {31'b0, done}, 0);
    chk(allZero, "R1 read data after reset", {31'b0, allZero}, 1);
  endtask

  task automatic tStride();
    int lat; bit bo; bit good;
    for (int l = 0; l < N; l++) setLane(l, 16'h1000 + 16'(4*l), 32'hA000_0000 + l);
    runOp('1, 0, 1, 0, lat, bo);
    chk(lat == 2, "R4 64-lane stride write latency", lat, 2);
    chk(bo, "R9 busy during stride write", {31'b0, bo}, 1);
    runOp('1, 0, 0, 0, lat, bo);
    chk(lat == 2, "R4 64-lane stride read latency", lat, 2);
    good = 1'b1;
    for (int l = 0; l < N; l++) if (rd(l) != 32'hA000_0000 + l) good = 1'b0;
    chk(good, "R10 stride read data at done", rd(5), 32'hA000_0005);
    for (int l = 0; l < 32; l++) setLane(l, 16'h1000 + 16'(4*(31-l)), 0);
    runOp({32'h0, 32'hFFFF_FFFF}, 0, 0, 0, lat, bo);
    chk(lat == 1, "R4 32-lane stride single cycle", lat, 1);
    chk(rd(0) == 32'hA000_001F, "R3 permuted stride lane0", rd(0), 32'hA000_001F);
  endtask

  task automatic tSameBank();
    int lat; bit bo; bit good;
    for (int l = 0; l < N; l++) setLane(l, 16'(l*128 + 4), 32'h0000_0B00 + l);
    runOp('1, 0, 1, 1, lat, bo);
    chk(lat == 64, "R5 one-bank write latency", lat, 64);
    chk(bo, "R9 busy through conflicted write", {31'b0, bo}, 1);
    for (int l = 0; l < N; l++) setLane(l, 16'(l*128 + 4), 0);
    runOp('1, 0, 0, 0, lat, bo);
    chk(lat == 64, "R5 one-bank read latency", lat, 64);
    good = 1'b1;
    for (int l = 0; l < N; l++) if (rd(l) != 32'h0000_0B00 + l) good = 1'b0;
    chk(good, "R9 mid-op start ignored, data intact", rd(10), 32'h0B0A);
  endtask

  task automatic tOffset();
    int lat; bit bo;
    setLane(0, 16'h3005, 32'h1111_2222);
    setLane(1, 16'h3085, 32'h3333_4444);
    runOp(64'h3, 0, 1, 0, lat, bo);
    chk(lat == 2, "R2 0x3005/0x3085 share a bank", lat, 2);
    setLane(0, 16'h3006, 0);
    setLane(1, 16'h3004, 0);
    runOp(64'h3, 0, 0, 0, lat, bo);
    chk(rd(0) == 32'h1111_2222 && rd(1) == 32'h1111_2222, "R2 byte offset ignored",
        rd(1), 32'h1111_2222);
    setLane(1, 16'h3009, 0);
    runOp(64'h3, 0, 0, 0, lat, bo);
    chk(lat == 1, "R2 adjacent words in distinct banks", lat, 1);
  endtask

  task automatic tMask();
    int lat; bit bo; bit good;
    for (int l = 0; l < N; l++) setLane(l, 16'(l*128 + 4), 0);
    runOp('1, 0, 0, 0, lat, bo);
    for (int l = 0; l < N; l++) setLane(l, 16'((63-l)*128 + 4), 0);
    runOp({32{2'b01}}, 0, 0, 0, lat, bo);
    chk(lat == 32, "R6 even-lane mask latency", lat, 32);
    good = 1'b1;
    for (int l = 0; l < N; l++) begin
      if (l % 2 == 0 && rd(l) != 32'h0B00 + (63-l)) good = 1'b0;
      if (l % 2 == 1 && rd(l) != 32'h0B00 + l) good = 1'b0;
    end
    chk(good, "R6 masked lanes keep data", rd(1), 32'h0B01);
    runOp('0, 0, 0, 0, lat, bo);
    chk(lat == 1, "R6 empty mask latency", lat, 1);
    chk(rd(1) == 32'h0B01 && rd(0) == 32'h0B3F, "R6 empty mask leaves data", rd(0), 32'h0B3F);
  endtask

  task automatic tSameAddr();
    int lat; bit bo;
    for (int l = 0; l < N; l++) setLane(l, 16'h5000, 32'h0000_0C00 + l);
    runOp('1, 0, 1, 0, lat, bo);
    chk(lat == 64, "R7 same-address write latency", lat, 64);
    chk(rd(2) == 32'h0B00 + 61, "R10 write leaves read data", rd(2), 32'h0B00 + 61);
    runOp(64'h1, 0, 0, 0, lat, bo);
    chk(rd(0) == 32'h0C3F, "R7 highest lane write persists", rd(0), 32'h0C3F);
  endtask

  task automatic tBcast();
    int lat; bit bo; bit good;
    for (int l = 0; l < N; l++) setLane(l, 16'(l*128 + 4), 32'hEEEE_0000 + l);
    runOp({{63{1'b1}}, 1'b0}, 1, 1, 0, lat, bo);
    chk(lat == 1, "R8 broadcast single cycle", lat, 1);
    good = 1'b1;
    for (int l = 1; l < N; l++) if (rd(l) != 32'h0B01) good = 1'b0;
    chk(good, "R8 broadcast word from lowest active lane", rd(40), 32'h0B01);
    chk(rd(0) == 32'h0C3F, "R8 inactive lane untouched", rd(0), 32'h0C3F);
    runOp(64'h2, 0, 0, 0, lat, bo);
    chk(rd(1) == 32'h0B01, "R8 broadcast does not write", rd(1), 32'h0B01);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tStride();
    tSameBank();
    tOffset();
    tMask();
    tSameAddr();
    tBcast();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule